// File: doc/BRIEF.md
# DMA Channel Semaphore Run Controller

This block decides, for one DMA channel, whether the channel runs or sits idle. It does this with a counting semaphore. Software adds credits through an increment port, and each credit stands for one pending unit of command work. The command engine reports every finished command together with the flags from that command's descriptor. When a finished command carries its decrement flag, one credit is used up. When the count reaches zero, the channel drops to idle. When credits appear again while the channel is idle, the block issues a single-cycle fetch request. That request carries the address taken from the channel's next-command-address register.

A peripheral can end the current descriptor early through its terminate line. This only takes effect if the running command has its halt-on-terminate flag set. In that case the block pulses a stop strobe back to the command engine, raises a sticky error interrupt, and parks the channel in a halted state. The channel leaves that state only through a software channel reset. The completion interrupt and the error interrupt are separate sticky bits, and each is cleared by software writing a one.

Top module: `dma_sem_runctl`

## Requirements
- R1: After `rst_n` is low, `sem_count` is 0, `run` is 0, and `fetch_req`, `desc_stop`, `irq_cmpl` and `irq_err` are all 0.
- R2: A cycle with `inc_valid` high adds `inc_amt` to the semaphore. The result saturates at 255 and never wraps.
- R3: A cycle with `cmd_done` high while running lowers the semaphore by one only when `cmd_dec` is 1. With `cmd_dec` at 0 the count is unchanged. While idle or halted, `cmd_done` has no effect on the count.
- R4: An increment and a decrement in the same cycle apply their net change, saturated at 255. A channel at count 1 that gets both stays running and issues no fetch.
- R5: A decrement that leaves the count at zero makes `run` low on the next cycle. The channel stays idle until an increment arrives.
- R6: When the count becomes non-zero while idle, `run` goes high and `fetch_req` is high for exactly one cycle. In that cycle `fetch_addr` equals the `nxt_addr` value sampled at the same edge. Increments while running issue no fetch.
- R7: A completed command with `cmd_irq_en` set makes `irq_cmpl` high. It stays high until a cycle with `clr_cmpl` high and no new completion event; a new event in the same cycle as a clear wins.
- R8: `term_in` while running with `cmd_hot` set gives a one-cycle `desc_stop`, sets `irq_err`, and drops `run`, with no decrement and no completion interrupt. With `cmd_hot` at 0, `term_in` has no effect.
- R9: A halted channel ignores `cmd_done` and issues no fetch, even when credits are added. It stays halted until a channel reset.
- R10: `chan_reset` clears the semaphore to 0, forces idle, and clears `irq_err`. It leaves `irq_cmpl` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| inc_valid | input | 1 | Software increment strobe |
| inc_amt | input | 8 | Amount to add to the semaphore |
| chan_reset | input | 1 | Software channel reset |
| clr_cmpl | input | 1 | Write-one clear of the completion interrupt |
| clr_err | input | 1 | Write-one clear of the error interrupt |
| nxt_addr | input | 32 | Next-command-address register value |
| cmd_done | input | 1 | Current command finished its transfer |
| cmd_dec | input | 1 | Decrement flag of the current command |
| cmd_irq_en | input | 1 | Interrupt-on-complete flag of the current command |
| cmd_hot | input | 1 | Halt-on-terminate flag of the current command |
| term_in | input | 1 | Terminate signal from the peripheral |
| run | output | 1 | Channel is running |
| sem_count | output | 8 | Semaphore value |
| fetch_req | output | 1 | One-cycle descriptor fetch request |
| fetch_addr | output | 32 | Address for the fetch |
| desc_stop | output | 1 | One-cycle strobe ending the current descriptor |
| irq_cmpl | output | 1 | Sticky completion interrupt |
| irq_err | output | 1 | Sticky terminate error interrupt |

## Verification
Every state bit of this block reaches the ports one edge after the input that changes it. A wrong count therefore shows on `sem_count` in the next cycle. A wrong run/idle decision shows as `run` disagreeing with a zero or non-zero count, or as a missing or extra `fetch_req` pulse in that same cycle. A halted state that leaks shows as `run`, `fetch_req` or a changing count during the cycles after a terminate. Interrupt bookkeeping faults show on the sticky interrupt outputs in the cycle after a set or clear.

// File: rtl/dma_sem_runctl.sv
module dma_sem_runctl #(
  parameter int SEM_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_valid,
  input  logic [SEM_W-1:0]  inc_amt,
  input  logic              chan_reset,
  input  logic              clr_cmpl,
  input  logic              clr_err,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              cmd_done,
  input  logic              cmd_dec,
  input  logic              cmd_irq_en,
  input  logic              cmd_hot,
  input  logic              term_in,
  output logic              run,
  output logic [SEM_W-1:0]  sem_count,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              desc_stop,
  output logic              irq_cmpl,
  output logic              irq_err
);

  localparam int WIDE_W = SEM_W + 2;
  localparam logic [WIDE_W-1:0] SEM_MAX = WIDE_W'((1 << SEM_W) - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} ch_state_e;

  ch_state_e state_q, state_d;
  logic [SEM_W-1:0] sem_q;
  logic [SEM_W-1:0] sem_d;
  logic [WIDE_W-1:0] sem_wide;

  wire running   = (state_q == ST_RUN);
  wire term_hit  = running && term_in && cmd_hot;
  wire done_ok   = running && cmd_done && !term_hit;
  wire dec_now   = done_ok && cmd_dec;
  wire cmpl_set  = done_ok && cmd_irq_en;

  assign sem_wide = {2'b00, sem_q}
                  + (inc_valid ? {2'b00, inc_amt} : '0)
                  - {{(WIDE_W-1){1'b0}}, dec_now};
  assign sem_d = (sem_wide > SEM_MAX) ? SEM_MAX[SEM_W-1:0] : sem_wide[SEM_W-1:0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (sem_d != '0) state_d = ST_RUN;
      ST_RUN: begin
        if (term_hit)          state_d = ST_HALT;
        else if (sem_d == '0)  state_d = ST_IDLE;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_IDLE;
    endcase
    if (chan_reset) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sem_q      <= '0;
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
      desc_stop  <= 1'b0;
      irq_cmpl   <= 1'b0;
      irq_err    <= 1'b0;
    end else begin
      state_q   <= state_d;
      sem_q     <= chan_reset ? '0 : sem_d;
      fetch_req <= !chan_reset && (state_q == ST_IDLE) && (sem_d != '0);
      if (!chan_reset && (state_q == ST_IDLE) && (sem_d != '0))
        fetch_addr <= nxt_addr;
      desc_stop <= term_hit && !chan_reset;
      if (cmpl_set)      irq_cmpl <= 1'b1;
      else if (clr_cmpl) irq_cmpl <= 1'b0;
      if (chan_reset)    irq_err <= 1'b0;
      else if (term_hit) irq_err <= 1'b1;
      else if (clr_err)  irq_err <= 1'b0;
    end
  end

  assign run       = running;
  assign sem_count = sem_q;

  assert_run_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (sem_q != '0));

  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q == SEM_MAX[SEM_W-1:0] && inc_valid && !dec_now && !chan_reset)
      |=> (sem_q == SEM_MAX[SEM_W-1:0]));

  assert_fetch_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

  assert_fetch_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> running);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |-> (!fetch_req && !run));

  assert_chan_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset |=> (sem_q == '0 && !irq_err && !running));

  assert_term_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (term_hit && !chan_reset) |=> (irq_err && desc_stop));

endmodule

// File: tb/test_dma_sem_runctl.sv
module test_dma_sem_runctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc_valid = 0, chan_reset = 0, clr_cmpl = 0, clr_err = 0;
  logic [7:0] inc_amt = '0;
  logic [31:0] nxt_addr = '0;
  logic cmd_done = 0, cmd_dec = 0, cmd_irq_en = 0, cmd_hot = 0, term_in = 0;
  logic run, fetch_req, desc_stop, irq_cmpl, irq_err;
  logic [7:0] sem_count;
  logic [31:0] fetch_addr;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  dma_sem_runctl i_dma_sem_runctl (
    .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_amt(inc_amt),
    .chan_reset(chan_reset), .clr_cmpl(clr_cmpl), .clr_err(clr_err),
    .nxt_addr(nxt_addr), .cmd_done(cmd_done), .cmd_dec(cmd_dec),
    .cmd_irq_en(cmd_irq_en), .cmd_hot(cmd_hot), .term_in(term_in),
    .run(run), .sem_count(sem_count), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .desc_stop(desc_stop),
    .irq_cmpl(irq_cmpl), .irq_err(irq_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    inc_valid = 0; chan_reset = 0; clr_cmpl = 0; clr_err = 0;
    cmd_done = 0; cmd_dec = 0; cmd_irq_en = 0; term_in = 0;
  endtask

  task automatic inc(input int amt);
    inc_valid = 1; inc_amt = 8'(amt);
  endtask

  task automatic done(input bit dec, input bit irq);
    cmd_done = 1; cmd_dec = dec; cmd_irq_en = irq;
  endtask

  task automatic t_reset();
    chk("R1 sem", sem_count, 0); chk("R1 run", run, 0);
    chk("R1 fetch", fetch_req, 0); chk("R1 stop", desc_stop, 0);
    chk("R1 cmpl", irq_cmpl, 0); chk("R1 err", irq_err, 0);
  endtask

  task automatic t_fetch();
    nxt_addr = 32'hA5A5_0000; inc(3); step();
    chk("R6 sem", sem_count, 3); chk("R6 run", run, 1);
    chk("R6 fetch", fetch_req, 1); chk("R6 addr", fetch_addr, 32'hA5A5_0000);
    nxt_addr = 32'h1234_5678; step();
    chk("R6 pulse", fetch_req, 0);
    inc(1); step();
    chk("R6 inc running", sem_count, 4); chk("R6 no refetch", fetch_req, 0);
  endtask

  task automatic t_decrement();
    done(1, 0); step(); chk("R3 dec", sem_count, 3);
    done(0, 0); step(); chk("R3 nodec", sem_count, 3);
  endtask

  task automatic t_net();
    inc(2); done(1, 0); step(); chk("R4 net", sem_count, 4);
    for (int i = 0; i < 3; i++) begin done(1, 0); step(); end
    chk("R3 count", sem_count, 1);
    inc(1); done(1, 0); step();
    chk("R4 hold", sem_count, 1); chk("R4 run", run, 1); chk("R4 nofetch", fetch_req, 0);
  endtask

  task automatic t_idle();
    done(1, 0); step();
    chk("R5 zero", sem_count, 0); chk("R5 idle", run, 0);
    done(1, 1); step();
    chk("R3 idle ignore", sem_count, 0); chk("R5 stay", run, 0);
    chk("R3 idle no irq", irq_cmpl, 0);
  endtask

  task automatic t_sat();
    nxt_addr = 32'h0000_BEE0; inc(200); step();
    chk("R2 add", sem_count, 200); chk("R6 refetch", fetch_req, 1);
    chk("R6 addr2", fetch_addr, 32'h0000_BEE0);
    inc(100); step(); chk("R2 sat", sem_count, 255);
    inc(5); done(1, 0); step(); chk("R4 sat net", sem_count, 255);
    inc(1); step(); chk("R2 full", sem_count, 255);
  endtask

  task automatic t_irq();
    done(0, 1); step(); chk("R7 set", irq_cmpl, 1);
    step(); chk("R7 sticky", irq_cmpl, 1);
    clr_cmpl = 1; step(); chk("R7 clr", irq_cmpl, 0);
    done(0, 1); clr_cmpl = 1; step(); chk("R7 set wins", irq_cmpl, 1);
    clr_cmpl = 1; step(); chk("R7 clr2", irq_cmpl, 0);
  endtask

  task automatic t_term();
    cmd_hot = 0; term_in = 1; step();
    chk("R8 nohot err", irq_err, 0); chk("R8 nohot run", run, 1);
    chk("R8 nohot stop", desc_stop, 0);
    cmd_hot = 1; term_in = 1; done(1, 1); step();
    chk("R8 stop", desc_stop, 1); chk("R8 err", irq_err, 1);
    chk("R8 halt", run, 0); chk("R8 nodec", sem_count, 255);
    chk("R8 nocmpl", irq_cmpl, 0);
    step(); chk("R8 stop pulse", desc_stop, 0);
    done(1, 1); step();
    chk("R9 ignore done", sem_count, 255); chk("R9 no irq", irq_cmpl, 0);
    for (int i = 0; i < 3; i++) begin
      step(); chk("R9 no fetch", fetch_req, 0); chk("R9 halted", run, 0);
    end
    cmd_hot = 0;
  endtask

  task automatic t_chreset();
    chan_reset = 1; step();
    chk("R10 sem", sem_count, 0); chk("R10 run", run, 0); chk("R10 err", irq_err, 0);
    inc(1); step(); chk("R10 recover", fetch_req, 1);
    done(0, 1); step(); chk("R7 cmpl set", irq_cmpl, 1);
    cmd_hot = 1; term_in = 1; step(); cmd_hot = 0;
    chk("R8 err again", irq_err, 1); chk("R9 halted2", run, 0);
    inc(4); step(); chk("R9 halted inc nofetch", fetch_req, 0);
    chan_reset = 1; step();
    chk("R10 sem2", sem_count, 0); chk("R10 err2", irq_err, 0);
    chk("R10 keep cmpl", irq_cmpl, 1); chk("R10 idle", run, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_fetch(); t_decrement(); t_net(); t_idle();
    t_sat(); t_irq(); t_term(); t_chreset();
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule